// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is an up-counter with two registers of the same width beside it. The primary register always holds a compare value. The secondary register works either as a second compare value or as a capture register. In capture mode, a qualified edge on an external input copies the running count into it. The counter has four run modes: stopped, free-running, restart on an external edge, and restart on a primary match. The restart modes turn the counter into an interval or period timer. The free-running mode combined with capture measures when external events happen.

Software reaches four registers through a plain write/read port: control, primary, secondary, and a read-only view of the counter. The external input is resynchronised before its edges are qualified. Each compare register gives a one-cycle match pulse, and a wrap of the counter gives a one-cycle overflow pulse.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, control, primary and secondary registers all read 0, and all three pulse outputs are low.
- R2: The register map is: address 0 is control, address 1 is primary, address 2 is secondary, address 3 is the counter. The control bits are edge select [4:3], run mode [2:1] and secondary-capture [0]. A write takes effect at the next clock edge. Reads are combinational. A write to address 3 is ignored.
- R3: Run mode 00 holds the counter at 0. In modes 01, 10 and 11 the counter advances by one at each clock edge where `cnt_en` is high, and holds where it is low.
- R4: A compare register holding value C pulses its match output for one cycle, in the cycle after the counter advances away from C. A value of 0 therefore fires on the 0-to-1 step after any clear, and never while the counter only sits at 0.
- R5: On a step from all-ones the counter wraps to 0, and `ovf_pulse` is high for one cycle in the same cycle that the counter reads 0.
- R6: In run mode 11, a step taken while the counter equals the primary value loads 0 instead of incrementing. The count period is then primary+1 steps, and no overflow pulse is raised for that step.
- R7: In run mode 10, a qualified external edge clears the counter whether or not `cnt_en` is high. In that cycle no step, match or overflow occurs.
- R8: Edge select 00 qualifies falling edges, 01 rising edges, 10 both edges, and 11 none. An input change made before clock edge k acts at clock edge k+2.
- R9: With secondary-capture set, a qualified edge copies the counter value from just before that edge (the pre-clear value, if a clear happens at the same edge) into the secondary register. The secondary match pulse stays low.
- R10: With secondary-capture clear, qualified edges leave the secondary register unchanged.
- R11: A software write to the secondary register at the same edge as a capture wins over the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable; one step per cycle while high |
| ext_in | input | 1 | Asynchronous external capture/clear input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WIDTH | Register read data (combinational) |
| prim_irq | output | 1 | One-cycle primary match pulse |
| sec_irq | output | 1 | One-cycle secondary match pulse (compare mode only) |
| ovf_pulse | output | 1 | One-cycle counter wrap pulse |

## Verification
The bench builds the timer with WIDTH set to 8. This brings a full wrap of the counter within 256 steps, so random runs can reach overflow, overflow inside the match-restart mode, and both capture and compare against values near all-ones. Compare values drawn from a small range make primary and secondary matches frequent. Occasional wide values exercise the large end of the range.

// File: rtl/capcmp_pkg.sv
`timescale 1ns/1ps
package capcmp_pkg;

    typedef enum logic [1:0] {
        RUN_STOP      = 2'b00,
        RUN_FREE      = 2'b01,
        RUN_EDGE_CLR  = 2'b10,
        RUN_MATCH_CLR = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e edge_sel;
        run_mode_e mode;
        logic      sec_cap;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int REG_AW    = 2;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_PRIM = 2'd1;
    localparam logic [REG_AW-1:0] A_SEC  = 2'd2;
    localparam logic [REG_AW-1:0] A_CNT  = 2'd3;

endpackage

// File: rtl/capcmp_edge.sv
`timescale 1ns/1ps
module capcmp_edge
    import capcmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_in,
    input  edge_sel_e edge_sel,
    output logic      edge_evt
);
    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist_d, hist_q;
    logic              cur, prev;

    always_comb begin
        hist_d = {hist_q[HIST_W-2:0], ext_in};
        cur    = hist_q[SYNC_STAGES-1];
        prev   = hist_q[SYNC_STAGES];
        unique case (edge_sel)
            EDGE_FALL: edge_evt = prev & ~cur;
            EDGE_RISE: edge_evt = cur & ~prev;
            EDGE_BOTH: edge_evt = cur ^ prev;
            default:   edge_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R8
    edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_OFF) |-> !edge_evt);

endmodule

// File: rtl/capcmp_match.sv
`timescale 1ns/1ps
module capcmp_match #(
    parameter int WIDTH = 16
) (
    input  logic             step,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] cmp,
    output logic             hit
);
    always_comb hit = step && (cnt == cmp);
endmodule

// File: rtl/capcmp_timer.sv
`timescale 1ns/1ps
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              prim_irq,
    output logic              sec_irq,
    output logic              ovf_pulse
);
    localparam int NCMP = 2;
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] prim;
        logic [WIDTH-1:0] sec;
        logic             irq_prim;
        logic             irq_sec;
        logic             ovf;
    } state_t;

    state_t           st_d, st_q;
    logic             edge_evt;
    logic             running, edge_clr, step;
    logic [NCMP-1:0]  hit;
    logic [WIDTH-1:0] cmp_vals [NCMP];

    capcmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .edge_sel (st_q.ctrl.edge_sel),
        .edge_evt (edge_evt)
    );

    always_comb begin
        cmp_vals[0] = st_q.prim;
        cmp_vals[1] = st_q.sec;
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        capcmp_match #(.WIDTH(WIDTH)) u_match (
            .step (step),
            .cnt  (st_q.cnt),
            .cmp  (cmp_vals[i]),
            .hit  (hit[i])
        );
    end

    always_comb begin
        running  = (st_q.ctrl.mode != RUN_STOP);
        edge_clr = (st_q.ctrl.mode == RUN_EDGE_CLR) && edge_evt;
        step     = running && cnt_en && !edge_clr;

        st_d          = st_q;
        st_d.irq_prim = hit[0];
        st_d.irq_sec  = hit[1] && !st_q.ctrl.sec_cap;
        st_d.ovf      = 1'b0;

        if (!running || edge_clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            if ((st_q.ctrl.mode == RUN_MATCH_CLR) && hit[0]) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.ovf = (st_q.cnt == CNT_MAX);
            end
        end

        if (st_q.ctrl.sec_cap && edge_evt) st_d.sec = st_q.cnt;

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_PRIM:  st_d.prim = wr_data;
                A_SEC:   st_d.sec  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = WIDTH'(st_q.ctrl);
            A_PRIM:  rd_data = st_q.prim;
            A_SEC:   rd_data = st_q.sec;
            default: rd_data = st_q.cnt;
        endcase
    end

    assign prim_irq  = st_q.irq_prim;
    assign sec_irq   = st_q.irq_sec;
    assign ovf_pulse = st_q.ovf;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode == RUN_STOP) |=> (st_q.cnt == '0));

    // R5
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> (st_q.cnt == '0));

    // R6
    match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ctrl.mode == RUN_MATCH_CLR) && cnt_en && (st_q.cnt == st_q.prim))
        |=> (st_q.cnt == '0));

    // R7
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ctrl.mode == RUN_EDGE_CLR) && edge_evt) |=> (st_q.cnt == '0));

    // R9
    cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.sec_cap |=> !st_q.irq_sec);

    // R10
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.sec_cap && !(wr_en && wr_addr == A_SEC)) |=> $stable(st_q.sec));

    // R4
    prim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq_prim |=> !st_q.irq_prim || (st_q.prim == '0) || $past(cnt_en));

endmodule

// File: tb/capcmp_timer_test.sv
`timescale 1ns/1ps
module capcmp_timer_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         ext_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         prim_irq, sec_irq, ovf_pulse;

    int total = 0;
    int bad   = 0;

    logic [4:0]   m_ctrl;
    logic [W-1:0] m_cnt, m_prim, m_sec;
    logic         m_ip, m_is, m_ov;
    logic [2:0]   m_h;

    capcmp_timer #(.WIDTH(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_in(ext_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .prim_irq(prim_irq), .sec_irq(sec_irq), .ovf_pulse(ovf_pulse)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0:    return W'(m_ctrl);
            2'd1:    return m_prim;
            2'd2:    return m_sec;
            default: return m_cnt;
        endcase
    endfunction

    task automatic model_step();
        logic         s, p, evt, clr, step, cap, ip, is, ov;
        logic [1:0]   mode;
        logic [W-1:0] n_cnt, n_prim, n_sec;
        logic [4:0]   n_ctrl;
        s = m_h[1];
        p = m_h[2];
        case (m_ctrl[4:3])
            2'b00:   evt = p & ~s;
            2'b01:   evt = s & ~p;
            2'b10:   evt = s ^ p;
            default: evt = 1'b0;
        endcase
        mode = m_ctrl[2:1];
        cap  = m_ctrl[0];
        n_cnt = m_cnt; n_prim = m_prim; n_sec = m_sec; n_ctrl = m_ctrl;
        ip = 1'b0; is = 1'b0; ov = 1'b0;
        clr  = (mode == 2'b10) && evt;
        step = (mode != 2'b00) && cnt_en && !clr;
        if (mode == 2'b00 || clr) n_cnt = '0;
        else if (step) begin
            ip = (m_cnt == m_prim);
            is = !cap && (m_cnt == m_sec);
            if (mode == 2'b11 && ip) n_cnt = '0;
            else begin
                n_cnt = m_cnt + 1'b1;
                ov = (m_cnt == {W{1'b1}});
            end
        end
        if (cap && evt) n_sec = m_cnt;
        if (wr_en) begin
            case (wr_addr)
                2'd0: n_ctrl = wr_data[4:0];
                2'd1: n_prim = wr_data;
                2'd2: n_sec  = wr_data;
                default: ;
            endcase
        end
        m_h = {m_h[1:0], ext_in};
        m_cnt = n_cnt; m_prim = n_prim; m_sec = n_sec; m_ctrl = n_ctrl;
        m_ip = ip; m_is = is; m_ov = ov;
    endtask

    task automatic tick(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(req, "rd_data", 32'(rd_data), 32'(exp_rd(rd_addr)));
        chk(req, "prim_irq", 32'(prim_irq), 32'(m_ip));
        chk(req, "sec_irq", 32'(sec_irq), 32'(m_is));
        chk(req, "ovf_pulse", 32'(ovf_pulse), 32'(m_ov));
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d, string req);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(req);
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic ticks(int n, string req);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd20240611));
        m_ctrl = '0; m_cnt = '0; m_prim = '0; m_sec = '0;
        m_ip = 0; m_is = 0; m_ov = 0; m_h = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk("R1", "reset reg", 32'(v), 0);
        end
        chk("R1", "prim_irq", 32'(prim_irq), 0);
        chk("R1", "sec_irq", 32'(sec_irq), 0);
        chk("R1", "ovf_pulse", 32'(ovf_pulse), 0);

        // R2 register access
        wr(2'd1, 8'd5, "R2");
        wr(2'd2, 8'd7, "R2");
        wr(2'd3, 8'h33, "R2");
        peek(2'd1, v); chk("R2", "primary", 32'(v), 5);
        peek(2'd2, v); chk("R2", "secondary", 32'(v), 7);
        peek(2'd3, v); chk("R2", "counter write ignored", 32'(v), 0);

        // R3 stopped mode holds zero even when enabled
        cnt_en = 1'b1;
        ticks(3, "R3");
        peek(2'd3, v); chk("R3", "stopped count", 32'(v), 0);

        // R4 zero compare: no match while idle at zero, match on 0->1
        wr(2'd1, 8'd0, "R4");
        wr(2'd2, 8'd0, "R4");
        cnt_en = 1'b0;
        wr(2'd0, 5'b00010, "R4");
        ticks(3, "R4");
        chk("R4", "idle prim_irq", 32'(prim_irq), 0);
        cnt_en = 1'b1;
        tick("R4");
        chk("R4", "zero prim_irq", 32'(prim_irq), 1);
        chk("R4", "zero sec_irq", 32'(sec_irq), 1);
        peek(2'd3, v); chk("R4", "count", 32'(v), 1);
        ticks(9, "R3");
        peek(2'd3, v); chk("R3", "free count", 32'(v), 10);
        cnt_en = 1'b0;
        ticks(2, "R3");
        peek(2'd3, v); chk("R3", "held count", 32'(v), 10);

        // R5 overflow
        cnt_en = 1'b1;
        wr(2'd1, 8'h80, "R5");
        wr(2'd2, 8'h80, "R5");
        rd_addr = 2'd3;
        for (int i = 0; i < 300 && rd_data != 8'hFF; i++) tick("R5");
        tick("R5");
        chk("R5", "ovf at wrap", 32'(ovf_pulse), 1);
        chk("R5", "count at wrap", 32'(rd_data), 0);

        // R6 match restart, period primary+1
        wr(2'd0, 5'b00000, "R6");
        wr(2'd1, 8'd4, "R6");
        wr(2'd0, 5'b00110, "R6");
        for (int i = 1; i <= 4; i++) begin
            tick("R6");
            peek(2'd3, v); chk("R6", "ramp", 32'(v), 32'(i));
        end
        tick("R6");
        peek(2'd3, v); chk("R6", "restart", 32'(v), 0);
        chk("R6", "prim_irq", 32'(prim_irq), 1);

        // R7 / R8 edge restart, latency and edge select
        wr(2'd0, 5'b00000, "R7");
        wr(2'd0, 5'b01100, "R7");
        ticks(5, "R7");
        ext_in = 1'b1;
        tick("R8");
        tick("R8");
        peek(2'd3, v); chk("R8", "not yet cleared", 32'(v), 7);
        tick("R7");
        peek(2'd3, v); chk("R7", "edge clear", 32'(v), 0);
        ext_in = 1'b0;
        ticks(3, "R8");
        peek(2'd3, v); chk("R8", "falling ignored", 32'(v), 3);
        wr(2'd0, 5'b11100, "R8");
        ext_in = 1'b1;
        ticks(4, "R8");
        peek(2'd3, v); chk("R8", "edge off", 32'(v), 8);
        wr(2'd0, 5'b10100, "R8");
        ext_in = 1'b0;
        ticks(3, "R8");
        peek(2'd3, v); chk("R8", "both edges", 32'(v), 0);

        // R9 capture
        wr(2'd0, 5'b00000, "R9");
        wr(2'd0, 5'b01011, "R9");
        ticks(5, "R9");
        ext_in = 1'b1;
        ticks(3, "R9");
        peek(2'd2, v); chk("R9", "captured", 32'(v), 7);
        wr(2'd2, 8'd10, "R9");
        ticks(2, "R9");
        chk("R9", "no sec_irq in capture", 32'(sec_irq), 0);

        // R11 write beats capture
        ext_in = 1'b0;
        ticks(3, "R11");
        ext_in = 1'b1;
        ticks(2, "R11");
        wr(2'd2, 8'h5A, "R11");
        peek(2'd2, v); chk("R11", "write wins", 32'(v), 32'h5A);

        // R10 compare mode ignores edges
        wr(2'd0, 5'b10010, "R10");
        wr(2'd2, 8'h33, "R10");
        ext_in = 1'b0;
        ticks(4, "R10");
        ext_in = 1'b1;
        ticks(4, "R10");
        peek(2'd2, v); chk("R10", "secondary held", 32'(v), 32'h33);

        // Random phase against the bench model
        for (int i = 0; i < 6000; i++) begin
            cnt_en  = ($urandom % 8) != 0;
            if ($urandom % 6 == 0) ext_in = ~ext_in;
            wr_en   = ($urandom % 16) == 0;
            wr_addr = 2'($urandom % 4);
            if (wr_addr == 2'd0)       wr_data = W'($urandom % 32);
            else if ($urandom % 4 == 0) wr_data = W'($urandom);
            else                        wr_data = W'($urandom % 16);
            rd_addr = 2'($urandom % 4);
            tick("R3");
        end
        wr_en = 1'b0;

        finish_run();
    end
endmodule